// File: doc/BRIEF.md
# SD/MMC Command and Response Sequencer

This block is the command engine of a memory-card host. Software programs a 6-bit command index, a 32-bit argument written as two 16-bit halves, a control word, a block length and a block count through a simple register port. Once a command is pending, the control word's stop-transfer bit is clear and the card clock is enabled, the block presents the command to a card-side interface. It then takes a single response beat that carries up to sixteen response bytes and a count of how many were returned.

The block sorts each response as complete or timed out. The rule depends on the response type in the control word and on the returned byte count. On completion it packs the bytes into a nine-entry FIFO of 16-bit words, which software drains by reading one register again and again. It raises an end-of-command request bit after every command. When a data phase follows, it loads a remaining-byte counter with the block count times the block length and shows that a transfer is active.

On the card side there are two valid/ready channels. The command channel (`cmd_valid`/`cmd_ready`) keeps `cmd_valid`, the index and the argument stable until `cmd_ready` is seen high at a clock edge. The response channel (`rsp_valid`/`rsp_ready`) asserts `rsp_ready` only after the command has been accepted, and only until the one response beat is taken. The card side may stall either channel for any number of cycles.

Top module: `sdcmd_seq`

## Requirements
- R1: After reset, the status, interrupt-request and response registers read 0, `cmd_valid` and `rsp_ready` are low, and `data_active` is low.
- R2: The command-index register (address 3) stores bits 5:0 of the written word. A read returns that index with bit 6 set to 1 and every bit above 6 at 0.
- R3: A write to address 4 replaces argument bits 31:16 with write bits 15:0. A write to address 5 replaces argument bits 15:0. Each write leaves the other half unchanged, and each address reads back its own half.
- R4: A write to the control word (address 2) stores the written value masked with 0x3DFF and marks a command pending. A pending command launches (`cmd_valid` rises) only while the clock is enabled and control bit 10 (stop-transfer) is 0. With bit 10 set, nothing is issued.
- R5: A write to address 0 with bit 1 set enables the clock (status bit 8). This also launches an already pending command whose bit 10 is 0. A write with bit 0 set disables the clock, and bit 0 wins if both bits are set.
- R6: `cmd_valid`, `cmd_index` and `cmd_arg` stay stable until `cmd_ready` is taken. `rsp_ready` is high only after the command has been accepted and never together with `cmd_valid`. Exactly one response beat is taken per command.
- R7: The response type is control bits 1:0 and is captured at launch. Type 0 always completes. Types 1 and 3 need at least 4 bytes, and type 2 needs at least 16. A shorter response sets status bit 1 (timeout); otherwise status bit 13 (response done) is set. The two bits are never set together.
- R8: On completion, response entry i is {byte 2i+1, byte 2i}, where byte k is `rsp_data[8k+7:8k]`. Bytes with index at or above `rsp_len` read as 0, and the read pointer returns to entry 0. A timed-out command leaves every entry 0.
- R9: Every finished command, whether complete or timed out, sets bit 2 of the interrupt-request register (address 9). The bit is cleared when the next command launches.
- R10: A launch clears status bits 1 and 13, keeps bit 8, and zeroes all nine response entries.
- R11: Each read of the response register (address 8) returns the next of nine entries in order. Once all nine have been read, it returns 0.
- R12: The block-length register (address 6) keeps 12 bits and the block-count register (address 7) keeps 16. On a completed command with control bit 2 set, `data_active` goes high and `data_remain` equals count times length, sampled at the completion edge. Otherwise `data_active` stays low. Disabling the clock drops `data_active`.
- R13: A response-register read in the same cycle as a completion returns the entry value from before that edge, and the pointer ends at entry 0, so the following read returns the new entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears on `reg_rdata` after the edge |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| cmd_valid | output | 1 | Command offered to the card side |
| cmd_ready | input | 1 | Card side accepts the command |
| cmd_index | output | 6 | Command index of the offered command |
| cmd_arg | output | 32 | Argument of the offered command |
| rsp_valid | input | 1 | Response beat present |
| rsp_ready | output | 1 | Sequencer waits for a response |
| rsp_len | input | 5 | Number of valid response bytes (0 to 16) |
| rsp_data | input | 128 | Response bytes, byte k in bits 8k+7:8k |
| data_active | output | 1 | A data phase follows the completed command |
| data_remain | output | 28 | Bytes to move in the data phase |

## Verification
The response register is drained by a read that moves a pointer, and a completing command resets that same pointer. A read of address 8 and the accepted response beat can therefore land on one clock edge. The bench provokes this by advancing the pointer past entry 0 with an earlier response, launching a new command, and driving `rsp_valid` and the response-register read on the same edge. The collided read must return the cleared pre-edge value, and the next two reads must return the new entries 0 and 1. Any other result shows that the pop overrode the reload.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  localparam int DATA_W = 32;
  localparam int ENT_W  = 16;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] ADR_CLK  = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_STAT = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_CTRL = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_IDX  = 4'd3;
  localparam logic [ADDR_W-1:0] ADR_ARGH = 4'd4;
  localparam logic [ADDR_W-1:0] ADR_ARGL = 4'd5;
  localparam logic [ADDR_W-1:0] ADR_BLEN = 4'd6;
  localparam logic [ADDR_W-1:0] ADR_BCNT = 4'd7;
  localparam logic [ADDR_W-1:0] ADR_RESP = 4'd8;
  localparam logic [ADDR_W-1:0] ADR_IRQ  = 4'd9;

  localparam int ST_TOUT   = 1;
  localparam int ST_CLK    = 8;
  localparam int ST_RSPDN  = 13;
  localparam int CT_DATA   = 2;
  localparam int CT_STOP   = 10;
  localparam int IRQ_ENDC  = 2;
  localparam int CK_STOP   = 0;
  localparam int CK_START  = 1;
  localparam logic [DATA_W-1:0] CTRL_KEEP = 32'h0000_3DFF;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_SEND = 2'd1,
    SQ_WAIT = 2'd2
  } seq_state_e;
endpackage

// File: rtl/sdcmd_fsm.sv
module sdcmd_fsm
  import sdcmd_pkg::*;
#(
  parameter int IDX_W       = 6,
  parameter int ARG_W       = 32,
  parameter int CNT_W       = 5,
  parameter int SHORT_BYTES = 4,
  parameter int LONG_BYTES  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pending,
  input  logic             clk_on,
  input  logic             stop_bit,
  input  logic [1:0]       rsp_type,
  input  logic [IDX_W-1:0] idx_in,
  input  logic [ARG_W-1:0] arg_in,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [IDX_W-1:0] cmd_index,
  output logic [ARG_W-1:0] cmd_arg,
  input  logic             rsp_valid,
  output logic             rsp_ready,
  input  logic [CNT_W-1:0] rsp_len,
  output logic             launch,
  output logic             done,
  output logic             timed_out
);
  localparam logic [CNT_W-1:0] NEED_SHORT = CNT_W'(SHORT_BYTES);
  localparam logic [CNT_W-1:0] NEED_LONG  = CNT_W'(LONG_BYTES);

  seq_state_e       st_q;
  logic [1:0]       type_q;
  logic [CNT_W-1:0] need;

  assign launch    = (st_q == SQ_IDLE) && pending && clk_on && !stop_bit;
  assign cmd_valid = (st_q == SQ_SEND);
  assign rsp_ready = (st_q == SQ_WAIT);
  assign done      = rsp_ready && rsp_valid;

  always_comb begin
    case (type_q)
      2'd0:    need = '0;
      2'd2:    need = NEED_LONG;
      default: need = NEED_SHORT;
    endcase
  end

  assign timed_out = done && (rsp_len < need);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= SQ_IDLE;
      type_q    <= 2'd0;
      cmd_index <= '0;
      cmd_arg   <= '0;
    end else begin
      case (st_q)
        SQ_IDLE: if (launch) begin
          st_q      <= SQ_SEND;
          type_q    <= rsp_type;
          cmd_index <= idx_in;
          cmd_arg   <= arg_in;
        end
        SQ_SEND: if (cmd_ready) st_q <= SQ_WAIT;
        SQ_WAIT: if (rsp_valid) st_q <= SQ_IDLE;
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assert_cmd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_index) && $stable(cmd_arg)));

  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && rsp_ready));

  assert_single_rsp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !rsp_ready);
endmodule

// File: rtl/sdcmd_respfifo.sv
module sdcmd_respfifo
  import sdcmd_pkg::*;
#(
  parameter int ENTRIES = 9,
  parameter int BYTES   = 16,
  parameter int CNT_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               load,
  input  logic               pop,
  input  logic [CNT_W-1:0]   rsp_len,
  input  logic [8*BYTES-1:0] rsp_data,
  output logic [ENT_W-1:0]   head
);
  localparam int PTR_W = $clog2(ENTRIES + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES);

  logic [ENTRIES-1:0][ENT_W-1:0] packed_w;
  logic [ENTRIES-1:0][ENT_W-1:0] ent_q;
  logic [PTR_W-1:0]              rptr_q;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_pack
    localparam int LO = 2 * g;
    localparam int HI = 2 * g + 1;
    if (LO < BYTES) begin : g_lo
      assign packed_w[g][7:0] = (rsp_len > CNT_W'(LO)) ? rsp_data[8*LO +: 8] : 8'h00;
    end else begin : g_lo_none
      assign packed_w[g][7:0] = 8'h00;
    end
    if (HI < BYTES) begin : g_hi
      assign packed_w[g][15:8] = (rsp_len > CNT_W'(HI)) ? rsp_data[8*HI +: 8] : 8'h00;
    end else begin : g_hi_none
      assign packed_w[g][15:8] = 8'h00;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_q <= '0;
    end else if (clear) begin
      ent_q <= '0;
    end else if (load) begin
      ent_q <= packed_w;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rptr_q <= '0;
    end else if (load) begin
      rptr_q <= '0;
    end else if (pop && rptr_q < LAST) begin
      rptr_q <= rptr_q + 1'b1;
    end
  end

  assign head = (rptr_q < LAST) ? ent_q[rptr_q] : '0;

  assert_rptr_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rptr_q <= LAST);

  assert_clear_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (ent_q == '0));
endmodule

// File: rtl/sdcmd_regs.sv
module sdcmd_regs
  import sdcmd_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int ARG_W  = 32,
  parameter int BLEN_W = 12,
  parameter int BCNT_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr,
  input  logic                     reg_rd,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [DATA_W-1:0]        reg_wdata,
  output logic [DATA_W-1:0]        reg_rdata,
  input  logic                     launch,
  input  logic                     done,
  input  logic                     timed_out,
  input  logic [ENT_W-1:0]         resp_head,
  output logic                     resp_pop,
  output logic                     pending,
  output logic                     clk_on,
  output logic                     stop_bit,
  output logic [1:0]               rsp_type,
  output logic [IDX_W-1:0]         idx,
  output logic [ARG_W-1:0]         arg,
  output logic                     data_active,
  output logic [BLEN_W+BCNT_W-1:0] data_remain
);
  localparam int HALF  = ARG_W / 2;
  localparam int REM_W = BLEN_W + BCNT_W;

  logic [DATA_W-1:0] ctrl_q;
  logic [BLEN_W-1:0] blen_q;
  logic [BCNT_W-1:0] bcnt_q;
  logic              st_tout_q;
  logic              st_rspdn_q;
  logic              irq_q;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] stat_w;
  logic [DATA_W-1:0] irq_w;
  logic [REM_W-1:0]  product;

  assign stop_bit = ctrl_q[CT_STOP];
  assign rsp_type = ctrl_q[1:0];
  assign resp_pop = reg_rd && (reg_addr == ADR_RESP);
  assign product  = REM_W'(bcnt_q) * REM_W'(blen_q);

  always_comb begin
    stat_w            = '0;
    stat_w[ST_TOUT]   = st_tout_q;
    stat_w[ST_CLK]    = clk_on;
    stat_w[ST_RSPDN]  = st_rspdn_q;
    irq_w             = '0;
    irq_w[IRQ_ENDC]   = irq_q;
  end

  always_comb begin
    case (reg_addr)
      ADR_STAT: rd_mux = stat_w;
      ADR_CTRL: rd_mux = ctrl_q;
      ADR_IDX:  rd_mux = DATA_W'({1'b1, idx});
      ADR_ARGH: rd_mux = DATA_W'(arg[ARG_W-1:HALF]);
      ADR_ARGL: rd_mux = DATA_W'(arg[HALF-1:0]);
      ADR_BLEN: rd_mux = DATA_W'(blen_q);
      ADR_BCNT: rd_mux = DATA_W'(bcnt_q);
      ADR_RESP: rd_mux = DATA_W'(resp_head);
      ADR_IRQ:  rd_mux = irq_w;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q      <= '0;
      blen_q      <= '0;
      bcnt_q      <= '0;
      idx         <= '0;
      arg         <= '0;
      pending     <= 1'b0;
      clk_on      <= 1'b0;
      st_tout_q   <= 1'b0;
      st_rspdn_q  <= 1'b0;
      irq_q       <= 1'b0;
      data_active <= 1'b0;
      data_remain <= '0;
      reg_rdata   <= '0;
    end else begin
      if (launch) begin
        pending     <= 1'b0;
        st_tout_q   <= 1'b0;
        st_rspdn_q  <= 1'b0;
        irq_q       <= 1'b0;
        data_active <= 1'b0;
      end
      if (done) begin
        irq_q <= 1'b1;
        if (timed_out) begin
          st_tout_q   <= 1'b1;
          data_active <= 1'b0;
        end else begin
          st_rspdn_q <= 1'b1;
          if (ctrl_q[CT_DATA]) begin
            data_active <= 1'b1;
            data_remain <= product;
          end else begin
            data_active <= 1'b0;
          end
        end
      end
      if (reg_wr) begin
        case (reg_addr)
          ADR_CLK: begin
            if (reg_wdata[CK_START]) clk_on <= 1'b1;
            if (reg_wdata[CK_STOP]) begin
              clk_on      <= 1'b0;
              data_active <= 1'b0;
            end
          end
          ADR_CTRL: begin
            ctrl_q  <= reg_wdata & CTRL_KEEP;
            pending <= 1'b1;
          end
          ADR_IDX:  idx <= reg_wdata[IDX_W-1:0];
          ADR_ARGH: arg[ARG_W-1:HALF] <= reg_wdata[HALF-1:0];
          ADR_ARGL: arg[HALF-1:0] <= reg_wdata[HALF-1:0];
          ADR_BLEN: blen_q <= reg_wdata[BLEN_W-1:0];
          ADR_BCNT: bcnt_q <= reg_wdata[BCNT_W-1:0];
          default: ;
        endcase
      end
      if (reg_rd) reg_rdata <= rd_mux;
    end
  end

  assert_endcmd_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> irq_q);

  assert_status_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_tout_q && st_rspdn_q));

  assert_pending_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !(reg_wr && reg_addr == ADR_CTRL)) |=> !pending);

  assert_idx_marker_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == ADR_IDX) |=> (reg_rdata[IDX_W] && reg_rdata[DATA_W-1:IDX_W+1] == '0));

  assert_launch_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> (clk_on && !ctrl_q[CT_STOP]));
endmodule

// File: rtl/sdcmd_seq.sv
module sdcmd_seq
  import sdcmd_pkg::*;
#(
  parameter int IDX_W        = 6,
  parameter int ARG_W        = 32,
  parameter int BLEN_W       = 12,
  parameter int BCNT_W       = 16,
  parameter int RESP_ENTRIES = 9,
  parameter int RESP_BYTES   = 16,
  parameter int SHORT_BYTES  = 4,
  parameter int CNT_W        = $clog2(RESP_BYTES + 1),
  parameter int REM_W        = BLEN_W + BCNT_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr,
  input  logic                    reg_rd,
  input  logic [3:0]              reg_addr,
  input  logic [31:0]             reg_wdata,
  output logic [31:0]             reg_rdata,
  output logic                    cmd_valid,
  input  logic                    cmd_ready,
  output logic [IDX_W-1:0]        cmd_index,
  output logic [ARG_W-1:0]        cmd_arg,
  input  logic                    rsp_valid,
  output logic                    rsp_ready,
  input  logic [CNT_W-1:0]        rsp_len,
  input  logic [8*RESP_BYTES-1:0] rsp_data,
  output logic                    data_active,
  output logic [REM_W-1:0]        data_remain
);
  logic             pending, clk_on, stop_bit;
  logic [1:0]       rsp_type;
  logic [IDX_W-1:0] idx;
  logic [ARG_W-1:0] arg;
  logic             launch, done, timed_out;
  logic             resp_pop;
  logic [ENT_W-1:0] resp_head;

  sdcmd_regs #(
    .IDX_W(IDX_W), .ARG_W(ARG_W), .BLEN_W(BLEN_W), .BCNT_W(BCNT_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .launch(launch), .done(done), .timed_out(timed_out),
    .resp_head(resp_head), .resp_pop(resp_pop),
    .pending(pending), .clk_on(clk_on), .stop_bit(stop_bit),
    .rsp_type(rsp_type), .idx(idx), .arg(arg),
    .data_active(data_active), .data_remain(data_remain)
  );

  sdcmd_fsm #(
    .IDX_W(IDX_W), .ARG_W(ARG_W), .CNT_W(CNT_W),
    .SHORT_BYTES(SHORT_BYTES), .LONG_BYTES(RESP_BYTES)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .pending(pending), .clk_on(clk_on), .stop_bit(stop_bit),
    .rsp_type(rsp_type), .idx_in(idx), .arg_in(arg),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_index(cmd_index), .cmd_arg(cmd_arg),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_len(rsp_len),
    .launch(launch), .done(done), .timed_out(timed_out)
  );

  sdcmd_respfifo #(
    .ENTRIES(RESP_ENTRIES), .BYTES(RESP_BYTES), .CNT_W(CNT_W)
  ) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .clear(launch), .load(done && !timed_out), .pop(resp_pop),
    .rsp_len(rsp_len), .rsp_data(rsp_data), .head(resp_head)
  );
endmodule

// File: tb/sdcmd_seq_test.sv
`timescale 1ns/1ps
module sdcmd_seq_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         cmd_valid, cmd_ready = 1'b0;
  logic [5:0]   cmd_index;
  logic [31:0]  cmd_arg;
  logic         rsp_valid = 1'b0, rsp_ready;
  logic [4:0]   rsp_len = '0;
  logic [127:0] rsp_data = '0;
  logic         data_active;
  logic [27:0]  data_remain;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sdcmd_seq uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_index(cmd_index),
    .cmd_arg(cmd_arg), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_len(rsp_len), .rsp_data(rsp_data), .data_active(data_active),
    .data_remain(data_remain)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  function automatic logic [127:0] mk_data(input logic [7:0] base);
    logic [127:0] v;
    for (int k = 0; k < 16; k++) v[8*k +: 8] = base + 8'(k);
    return v;
  endfunction

  function automatic logic [31:0] exp_ent(input logic [127:0] d, input int len, input int i);
    logic [7:0] lo, hi;
    lo = (2*i < len && 2*i < 16) ? d[8*(2*i) +: 8] : 8'h00;
    hi = (2*i+1 < len && 2*i+1 < 16) ? d[8*(2*i+1) +: 8] : 8'h00;
    return {16'h0, hi, lo};
  endfunction

  // card side: wait for offer, accept it, return one response beat
  task automatic serve(input int len, input logic [127:0] d, input bit pop_same,
                       output logic [31:0] popped);
    int n = 0;
    popped = '0;
    while (!cmd_valid && n < 30) begin @(negedge clk); n++; end
    chk("R6 command offered", 32'(cmd_valid), 32'd1);
    chk("R6 no rsp_ready before accept", 32'(rsp_ready), 32'd0);
    cmd_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_ready = 1'b0;
    chk("R6 rsp_ready after accept", 32'(rsp_ready), 32'd1);
    chk("R6 offer dropped after accept", 32'(cmd_valid), 32'd0);
    rsp_valid = 1'b1; rsp_len = 5'(len); rsp_data = d;
    if (pop_same) begin reg_rd = 1'b1; reg_addr = 4'd8; end
    @(posedge clk);
    @(negedge clk);
    rsp_valid = 1'b0;
    if (pop_same) begin reg_rd = 1'b0; popped = reg_rdata; end
    chk("R6 one response per command", 32'(rsp_ready), 32'd0);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 cmd_valid", 32'(cmd_valid), 32'd0);
    chk("R1 rsp_ready", 32'(rsp_ready), 32'd0);
    chk("R1 data_active", 32'(data_active), 32'd0);
    rd(4'd1, v); chk("R1 status", v, 32'h0);
    rd(4'd9, v); chk("R1 irq", v, 32'h0);
    rd(4'd8, v); chk("R1 resp", v, 32'h0);
  endtask

  task automatic t_fields;
    logic [31:0] v;
    wr(4'd3, 32'hFFFF_FFD5); rd(4'd3, v); chk("R2 index readback", v, 32'h55);
    wr(4'd3, 32'h0000_003F); rd(4'd3, v); chk("R2 index readback max", v, 32'h7F);
    wr(4'd4, 32'h1234_ABCD); wr(4'd5, 32'h9999_5678);
    rd(4'd4, v); chk("R3 arg high", v, 32'hABCD);
    rd(4'd5, v); chk("R3 arg low", v, 32'h5678);
    wr(4'd4, 32'h0000_1111);
    rd(4'd5, v); chk("R3 low kept", v, 32'h5678);
    rd(4'd4, v); chk("R3 high replaced", v, 32'h1111);
  endtask

  task automatic t_gate;
    logic [31:0] v;
    wr(4'd2, 32'hFFFF_FFFF);
    rd(4'd2, v); chk("R4 ctrl mask", v, 32'h3DFF);
    wr(4'd0, 32'h2);
    repeat (4) @(negedge clk);
    chk("R4 stop bit blocks launch", 32'(cmd_valid), 32'd0);
    rd(4'd1, v); chk("R5 clock on", v, 32'h100);
    wr(4'd0, 32'h3);
    rd(4'd1, v); chk("R5 stop wins", v, 32'h0);
    wr(4'd2, 32'h1);
    repeat (4) @(negedge clk);
    chk("R5 no launch with clock off", 32'(cmd_valid), 32'd0);
  endtask

  task automatic t_clk_launch;
    logic [31:0] v, p;
    logic [127:0] d;
    d = mk_data(8'h30);
    wr(4'd0, 32'h2);
    repeat (2) @(negedge clk);
    chk("R5 clock start launches", 32'(cmd_valid), 32'd1);
    chk("R6 index on offer", 32'(cmd_index), 32'h3F);
    chk("R6 arg on offer", cmd_arg, 32'h1111_5678);
    serve(4, d, 1'b0, p);
    rd(4'd1, v); chk("R7 type1 len4 complete", v, 32'h2100);
    rd(4'd9, v); chk("R9 irq on complete", v, 32'h4);
    rd(4'd8, v); chk("R8 entry0", v, exp_ent(d, 4, 0));
    rd(4'd8, v); chk("R8 entry1", v, exp_ent(d, 4, 1));
    rd(4'd8, v); chk("R8 entry2 beyond count", v, 32'h0);
  endtask

  task automatic t_type(input logic [1:0] ty, input int len, input bit tout, input bit look);
    logic [31:0] v, p;
    logic [127:0] d;
    d = mk_data(8'h80 + 8'(len));
    wr(4'd2, 32'(ty));
    if (look) begin
      rd(4'd1, v); chk("R10 status cleared at launch", v, 32'h100);
      rd(4'd9, v); chk("R9 irq cleared at launch", v, 32'h0);
      rd(4'd8, v); chk("R10 fifo zeroed at launch", v, 32'h0);
    end
    serve(len, d, 1'b0, p);
    rd(4'd1, v); chk(tout ? "R7 timeout status" : "R7 complete status", v, tout ? 32'h102 : 32'h2100);
    rd(4'd9, v); chk("R9 irq every command", v, 32'h4);
    for (int i = 0; i < 9; i++) begin
      rd(4'd8, v);
      chk(tout ? "R8 timeout leaves zeros" : "R11 entry order", v, tout ? 32'h0 : exp_ent(d, len, i));
    end
    rd(4'd8, v); chk("R11 read past nine", v, 32'h0);
  endtask

  task automatic t_data;
    logic [31:0] v, p;
    wr(4'd6, 32'h0000_F200); rd(4'd6, v); chk("R12 length 12 bits", v, 32'h200);
    wr(4'd7, 32'h0001_0003); rd(4'd7, v); chk("R12 count 16 bits", v, 32'h3);
    wr(4'd2, 32'h5);
    wr(4'd6, 32'd100);
    serve(4, mk_data(8'h10), 1'b0, p);
    chk("R12 data active", 32'(data_active), 32'd1);
    chk("R12 remain sampled at completion", 32'(data_remain), 32'd300);
    wr(4'd0, 32'h1);
    chk("R12 clock stop drops data", 32'(data_active), 32'd0);
    wr(4'd0, 32'h2);
    wr(4'd2, 32'h6);
    serve(4, mk_data(8'h20), 1'b0, p);
    chk("R12 timeout no data", 32'(data_active), 32'd0);
    wr(4'd2, 32'h1);
    serve(4, mk_data(8'h20), 1'b0, p);
    chk("R12 no data without enable", 32'(data_active), 32'd0);
  endtask

  task automatic t_collide;
    logic [31:0] v, p;
    logic [127:0] d;
    wr(4'd2, 32'h2);
    serve(16, mk_data(8'h40), 1'b0, p);
    rd(4'd8, v); rd(4'd8, v);
    d = 128'h0;
    d[31:0] = 32'h4433_2211;
    wr(4'd2, 32'h1);
    serve(4, d, 1'b1, p);
    chk("R13 collided read sees pre-edge value", p, 32'h0);
    rd(4'd8, v); chk("R13 pointer reset to entry0", v, 32'h2211);
    rd(4'd8, v); chk("R13 then entry1", v, 32'h4433);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_gate();
    t_clk_launch();
    t_type(2'd0, 0, 1'b0, 1'b0);
    t_type(2'd1, 3, 1'b1, 1'b1);
    t_type(2'd3, 4, 1'b0, 1'b1);
    t_type(2'd2, 15, 1'b1, 1'b0);
    t_type(2'd2, 16, 1'b0, 1'b0);
    t_type(2'd3, 7, 1'b0, 1'b0);
    t_data();
    t_collide();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule